// File: doc/BRIEF.md
# DMX512 Packet Transmitter

This block drives one serial lighting-control line. When a start strobe is accepted, it pulls the line low for a timed break and then holds it high for a short mark. After that it sends a continuous run of asynchronous serial slots. Each slot has one start bit, eight data bits sent least-significant first, no parity bit, and two stop bits. The first slots carry the bytes held in a small value buffer, in address order. Zero-valued padding slots follow. The number of padding slots depends on a configured slot count. A fixed tail of zero slots closes the packet.

Software or a neighbouring block loads the buffer through a simple write port at any time. The buffer contents and the slot count are captured when a packet begins, so a write made during a packet only takes effect in the next packet. The line idles high. `busy_o` is high from the first break cycle through the last stop bit. `done_o` pulses for one cycle after that. The sequencer moves through these states: IDLE, BREAK, MARK, BUFSLOT, PADSLOT, TAILSLOT, DONE. The transitions are:

- IDLE→BREAK on an accepted start.
- BREAK→MARK after `BREAK_CYCLES`.
- MARK→BUFSLOT after `MARK_CYCLES`.
- BUFSLOT→PADSLOT after the last buffered slot if any padding is owed.
- BUFSLOT→TAILSLOT after the last buffered slot if no padding is owed.
- PADSLOT→TAILSLOT after the last padding slot.
- TAILSLOT→DONE after the last tail slot.
- DONE→IDLE after one cycle.

Top module: `dmx_tx`

## Requirements
- R1: Out of reset, and whenever no packet is in progress, `tx_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: Each slot occupies 11 bit periods of `CLK_PER_BIT` cycles each, in this order: a start bit at 0, then data bit 0 through data bit 7, then two stop bits at 1.
- R3: A start strobe accepted at a clock edge makes `tx_o` low from the next cycle for exactly `BREAK_CYCLES` cycles.
- R4: The break is followed by `tx_o` high for exactly `MARK_CYCLES` cycles, and then the start bit of the first slot.
- R5: The first `BUF_DEPTH` slots carry buffer entries 0, 1, …, `BUF_DEPTH`-1, in that order.
- R6: The buffered slots are followed by max(`PAD_BASE` − `slot_cfg_i`, 0) slots of value 0x00, where `slot_cfg_i` is sampled when the packet is accepted.
- R7: `TAIL_SLOTS` further slots of value 0x00 follow, and then the packet ends.
- R8: `busy_o` is 1 from the first break cycle through the last stop-bit cycle. In the following cycle, `done_o` is 1 for exactly one cycle with `busy_o` 0 and `tx_o` 1.
- R9: A start strobe is accepted only while the sequencer is idle. A strobe while `busy_o` or `done_o` is 1 has no effect on `tx_o`.
- R10: A buffer write with `wr_en_i` at 1 stores `wr_data_i` at entry `wr_addr_i`, and addresses at or above `BUF_DEPTH` are dropped. A packet uses the buffer contents as they stood before its accepting edge. A write in that same edge, or during the packet, first appears in the next packet.
- R11: A slot's start bit begins in the cycle right after the previous slot's last stop-bit cycle, with no gap and no overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Packet start strobe |
| wr_en_i | input | 1 | Buffer write enable |
| wr_addr_i | input | $clog2(BUF_DEPTH) | Buffer write address |
| wr_data_i | input | 8 | Buffer write byte |
| slot_cfg_i | input | CFG_W | Configured slot count used for the padding length |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle end-of-packet pulse |

## Verification
Three pairs of events can land in the same cycle, and each pair is provoked on purpose:

- A start strobe in the single DONE cycle. The bench raises `start_i` on the cycle that shows `done_o`, and judges the strobe correct only if the line stays idle afterwards.
- A buffer write in the very edge that accepts a start. The bench applies both in one cycle, and the packet on the wire must carry the old byte while the following packet carries the new one.
- The end of one slot and the load of the next. These meet on every slot boundary, and the behavioural reference requires the next start bit in the very next cycle.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_MARK,
        ST_BUFSLOT,
        ST_PADSLOT,
        ST_TAILSLOT,
        ST_DONE
    } seq_state_t;

    localparam int FRAME_BITS = 11;
    localparam int DATA_BITS  = 8;

endpackage

// File: rtl/dmx_bit_timer.sv
module dmx_bit_timer #(
    parameter int CLK_PER_BIT = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic bit_end_o
);
    localparam int CNT_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign bit_end_o = run_i && (cnt_q == CNT_W'(CLK_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= bit_end_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < CLK_PER_BIT); // R2

endmodule

// File: rtl/dmx_slot_framer.sv
module dmx_slot_framer
    import dmx_tx_pkg::*;
#(
    parameter int CLK_PER_BIT = 800
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [DATA_BITS-1:0] byte_i,
    output logic                 line_o,
    output logic                 slot_end_o
);
    logic [FRAME_BITS-1:0] shreg_q;
    logic [3:0]            bitn_q;
    logic                  active_q;
    logic                  bit_end;

    dmx_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load_i),
        .run_i     (active_q),
        .bit_end_o (bit_end)
    );

    assign slot_end_o = bit_end && (bitn_q == 4'(FRAME_BITS - 1));
    assign line_o     = active_q ? shreg_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '1;
            bitn_q   <= '0;
            active_q <= 1'b0;
        end else if (load_i) begin
            shreg_q  <= {2'b11, byte_i, 1'b0};
            bitn_q   <= '0;
            active_q <= 1'b1;
        end else if (bit_end) begin
            if (bitn_q == 4'(FRAME_BITS - 1)) begin
                active_q <= 1'b0;
            end else begin
                shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                bitn_q  <= bitn_q + 4'd1;
            end
        end
    end

    AST_STOP_HIGH:   assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && bitn_q >= 4'(FRAME_BITS - 2)) |-> line_o); // R2
    AST_START_LOW:   assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) |-> !line_o); // R2
    AST_NO_OVERLAP:  assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!active_q || slot_end_o)); // R11

endmodule

// File: rtl/dmx_slot_buf.sv
module dmx_slot_buf
    import dmx_tx_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_BITS-1:0] wr_data_i,
    input  logic                 snap_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_BITS-1:0] rd_data_o
);
    logic [DATA_BITS-1:0] stage_q [DEPTH];
    logic [DATA_BITS-1:0] work_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
                work_q[g]  <= '0;
            end else begin
                if (snap_i) begin
                    work_q[g] <= stage_q[g];
                end
                if (wr_en_i && (wr_addr_i == ADDR_W'(g))) begin
                    stage_q[g] <= wr_data_i;
                end
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr_i == ADDR_W'(i)) begin
                rd_data_o = work_q[i];
            end
        end
    end

endmodule

// File: rtl/dmx_tx.sv
module dmx_tx
    import dmx_tx_pkg::*;
#(
    parameter int CLK_PER_BIT  = 800,
    parameter int BREAK_CYCLES = 18000,
    parameter int MARK_CYCLES  = 1600,
    parameter int BUF_DEPTH    = 32,
    parameter int PAD_BASE     = 258,
    parameter int TAIL_SLOTS   = 255,
    parameter int CFG_W        = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         wr_en_i,
    input  logic [$clog2(BUF_DEPTH)-1:0] wr_addr_i,
    input  logic [7:0]                   wr_data_i,
    input  logic [CFG_W-1:0]             slot_cfg_i,
    output logic                         tx_o,
    output logic                         busy_o,
    output logic                         done_o
);
    localparam int ADDR_W  = $clog2(BUF_DEPTH);
    localparam int PH_MAX  = (BREAK_CYCLES > MARK_CYCLES) ? BREAK_CYCLES : MARK_CYCLES;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int MAX_AB  = (BUF_DEPTH > PAD_BASE) ? BUF_DEPTH : PAD_BASE;
    localparam int MAX_S   = (MAX_AB > TAIL_SLOTS) ? MAX_AB : TAIL_SLOTS;
    localparam int SLOT_W  = $clog2(MAX_S + 1);

    seq_state_t          state_q, state_nx;
    logic [PH_W-1:0]     phase_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [SLOT_W-1:0]   pad_len_q;
    logic                accept;
    logic                phase_last;
    logic                buf_last, pad_last, tail_last;
    logic                load;
    logic [7:0]          load_byte;
    logic [ADDR_W-1:0]   rd_addr;
    logic [7:0]          rd_data;
    logic                frm_line;
    logic                slot_end;

    dmx_slot_buf #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .snap_i    (accept),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    dmx_slot_framer #(.CLK_PER_BIT(CLK_PER_BIT)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .byte_i     (load_byte),
        .line_o     (frm_line),
        .slot_end_o (slot_end)
    );

    assign accept     = (state_q == ST_IDLE) && start_i;
    assign phase_last = ((state_q == ST_BREAK) && (phase_q == PH_W'(BREAK_CYCLES - 1))) ||
                        ((state_q == ST_MARK)  && (phase_q == PH_W'(MARK_CYCLES - 1)));
    assign buf_last   = (slot_q == SLOT_W'(BUF_DEPTH - 1));
    assign pad_last   = (slot_q == pad_len_q - SLOT_W'(1));
    assign tail_last  = (slot_q == SLOT_W'(TAIL_SLOTS - 1));
    assign rd_addr    = (state_q == ST_MARK) ? '0 : ADDR_W'(slot_q + SLOT_W'(1));

    // next-state decode
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)    state_nx = ST_BREAK;
            ST_BREAK:    if (phase_last) state_nx = ST_MARK;
            ST_MARK:     if (phase_last) state_nx = ST_BUFSLOT;
            ST_BUFSLOT:  if (slot_end && buf_last)
                             state_nx = (pad_len_q == '0) ? ST_TAILSLOT : ST_PADSLOT;
            ST_PADSLOT:  if (slot_end && pad_last)  state_nx = ST_TAILSLOT;
            ST_TAILSLOT: if (slot_end && tail_last) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= '0;
            slot_q    <= '0;
            pad_len_q <= '0;
        end else begin
            state_q <= state_nx;
            phase_q <= (state_nx != state_q) ? '0 : phase_q + PH_W'(1);
            if (state_nx != state_q) begin
                slot_q <= '0;
            end else if (slot_end) begin
                slot_q <= slot_q + SLOT_W'(1);
            end
            if (accept) begin
                if (32'(slot_cfg_i) >= PAD_BASE) begin
                    pad_len_q <= '0;
                end else begin
                    pad_len_q <= SLOT_W'(PAD_BASE - 32'(slot_cfg_i));
                end
            end
        end
    end

    // outputs and slot loading
    always_comb begin
        load      = 1'b0;
        load_byte = '0;
        tx_o      = 1'b1;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BREAK: begin
                tx_o   = 1'b0;
                busy_o = 1'b1;
            end
            ST_MARK: begin
                busy_o    = 1'b1;
                load      = phase_last;
                load_byte = rd_data;
            end
            ST_BUFSLOT: begin
                busy_o    = 1'b1;
                tx_o      = frm_line;
                load      = slot_end;
                load_byte = buf_last ? 8'h00 : rd_data;
            end
            ST_PADSLOT: begin
                busy_o = 1'b1;
                tx_o   = frm_line;
                load   = slot_end;
            end
            ST_TAILSLOT: begin
                busy_o = 1'b1;
                tx_o   = frm_line;
                load   = slot_end && !tail_last;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    AST_BREAK_LEN:     assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MARK && $past(state_q) == ST_BREAK) |->
            $past(phase_q) == PH_W'(BREAK_CYCLES - 1)); // R3
    AST_MARK_LEN:      assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUFSLOT && $past(state_q) == ST_MARK) |->
            $past(phase_q) == PH_W'(MARK_CYCLES - 1)); // R4
    AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER:    assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o && tx_o)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || done_o) |=> !(busy_o && !$past(busy_o))); // R9
    AST_IDLE_HIGH:     assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o); // R1

endmodule

// File: tb/dmx_tx_bench.sv
module dmx_tx_bench;
    localparam int CPB    = 4;
    localparam int BRK    = 23;
    localparam int MRK    = 6;
    localparam int DEPTH  = 8;
    localparam int PADB   = 12;
    localparam int TAIL   = 5;
    localparam int CFGW   = 5;
    localparam int AW     = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [CFGW-1:0] cfg = '0;
    logic            tx, busy, done;

    dmx_tx #(
        .CLK_PER_BIT(CPB), .BREAK_CYCLES(BRK), .MARK_CYCLES(MRK),
        .BUF_DEPTH(DEPTH), .PAD_BASE(PADB), .TAIL_SLOTS(TAIL), .CFG_W(CFGW)
    ) u_dmx_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .slot_cfg_i(cfg),
        .tx_o(tx), .busy_o(busy), .done_o(done)
    );

    always #2.5 clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    logic  q_line [$];
    string q_tag  [$];
    logic [7:0] mirror [DEPTH];
    logic  exp_line = 1'b1, exp_busy = 1'b0, exp_done = 1'b0;
    string exp_tag = "R1";

    task automatic push_slot(input logic [7:0] b, input string dtag, input bit first);
        for (int k = 0; k < 11; k++) begin
            logic  v;
            string t;
            if (k == 0) begin v = 1'b0; t = first ? "R2" : "R2/R11"; end
            else if (k <= 8) begin v = b[k-1]; t = dtag; end
            else begin v = 1'b1; t = "R2"; end
            for (int c = 0; c < CPB; c++) begin q_line.push_back(v); q_tag.push_back(t); end
        end
    endtask

    // behavioural reference, advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q_line.delete(); q_tag.delete();
            exp_line = 1'b1; exp_busy = 1'b0; exp_done = 1'b0; exp_tag = "R1";
            for (int i = 0; i < DEPTH; i++) mirror[i] = 8'h00;
        end else begin
            if (start && q_line.size() == 0 && !exp_busy && !exp_done) begin
                int pad;
                pad = (int'(cfg) >= PADB) ? 0 : PADB - int'(cfg);
                for (int i = 0; i < BRK; i++) begin q_line.push_back(1'b0); q_tag.push_back("R3"); end
                for (int i = 0; i < MRK; i++) begin q_line.push_back(1'b1); q_tag.push_back("R4"); end
                for (int s = 0; s < DEPTH; s++) push_slot(mirror[s], "R5/R10", s == 0);
                for (int s = 0; s < pad; s++)   push_slot(8'h00, "R6", 1'b0);
                for (int s = 0; s < TAIL; s++)  push_slot(8'h00, "R7", 1'b0);
            end
            if (q_line.size() > 0) begin
                exp_line = q_line.pop_front(); exp_tag = q_tag.pop_front();
                exp_busy = 1'b1; exp_done = 1'b0;
            end else if (exp_busy) begin
                exp_line = 1'b1; exp_busy = 1'b0; exp_done = 1'b1; exp_tag = "R8";
            end else begin
                exp_line = 1'b1; exp_done = 1'b0; exp_tag = "R1";
            end
            if (wr_en && int'(wr_addr) < DEPTH) mirror[wr_addr] = wr_data;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        vectors++;
        if (tx !== exp_line) begin
            miscompares++;
            $display("FAIL %s tx_o cycle %0d: got %b expected %b", exp_tag, cycles, tx, exp_line);
        end else if (busy !== exp_busy || done !== exp_done) begin
            miscompares++;
            $display("FAIL R8/R9 busy/done cycle %0d: got %b/%b expected %b/%b",
                     cycles, busy, done, exp_busy, exp_done);
        end
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic write_byte(input int a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);      // R1 reset state checked each cycle
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        write_byte(0, 8'hA5); write_byte(1, 8'h01); write_byte(2, 8'h80);
        write_byte(3, 8'hFF); write_byte(4, 8'h3C); write_byte(5, 8'h00);
        write_byte(6, 8'h7E); write_byte(7, 8'h96);
        cfg = 5'd3;                     // R6 nine padding slots
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();                  // R9 strobe while busy
        write_byte(0, 8'h5A);           // R10 takes effect next packet
        cfg = 5'd12;                    // R6 no padding next time
        @(negedge clk);
        while (!done) @(negedge clk);
        start = 1'b1;                   // R9 strobe in the done cycle
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        // R10 write in the same edge that accepts the start
        @(negedge clk); start = 1'b1; wr_en = 1'b1; wr_addr = AW'(1); wr_data = 8'hC3;
        @(negedge clk); start = 1'b0; wr_en = 1'b0;
        wait_idle();
        cfg = 5'd20;                    // R6 clamp to zero padding
        pulse_start();
        wait_idle();
        cfg = 5'd0;                     // R6 full padding, R7 tail
        pulse_start();
        wait_idle();
        // R11 back-to-back packet right after idle
        pulse_start();
        wait_idle();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule